// File: doc/BRIEF.md
# Packed SAD and Byte Average Unit

This unit is a 32-bit packed-integer datapath for media kernels such as motion estimation and pixel blending. One operation is presented per cycle on three operands A, B and C together with an operation select. The sum-of-absolute-differences forms take the unsigned magnitudes of the differences between A and B, lane by lane at byte, halfword or full-word size, add those magnitudes together and add the accumulator operand C. A high-placement variant moves the byte sum up by sixteen bits before adding C, so that two partial sums can share one 32-bit accumulator.

The average operation works on each of the four bytes on its own. It adds the A byte, the B byte and one rounding bit, then halves the result. The rounding bit for a byte is the least significant bit of the matching byte of C, so each lane may round or truncate independently. The result goes through one register stage and appears with a valid flag one cycle after the operation is accepted.

Top module: `psad_unit`

## Requirements
- R1: With op = 0 the result is C + |A[7:0]-B[7:0]| + |A[15:8]-B[15:8]| + |A[23:16]-B[23:16]| + |A[31:24]-B[31:24]|, where each difference is an unsigned magnitude.
- R2: With op = 1 the result is C + (byte SAD sum << 16). The byte SAD sum is formed as in R1.
- R3: With op = 2 the result is C + |A[15:0]-B[15:0]| + |A[31:16]-B[31:16]|, where each difference is an unsigned magnitude.
- R4: With op = 3 the result is C + |A-B|, with A and B treated as unsigned 32-bit values.
- R5: With op = 4, byte k of the result (bits 8k+7:8k) is (A byte k + B byte k + C[8k]) >> 1. The lane sum keeps its ninth bit, so 0xFF + 0xFF + 1 gives 0xFF.
- R6: The final addition of C wraps modulo 2^32 in every SAD form.
- R7: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low. When out_valid is high, result holds the value for the operands accepted in that earlier cycle.
- R8: A synchronous active-high rst clears result to 0 and out_valid to 0 at the next clock edge. This applies even when in_valid is high.
- R9: The op codes 5, 6 and 7 produce a result of 0.
- R10: With op = 4, bits 7:1 of each byte of C have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 3 | Operation select: 0 byte SAD, 1 high byte SAD, 2 halfword SAD, 3 word SAD, 4 byte average |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| c | input | 32 | Accumulator for the SAD forms; per-byte rounding bits for the average |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Registered result |

## Verification
Every operation, and the reset, takes effect at the first rising edge after it is presented. The bench therefore drives inputs on a falling edge and checks result and out_valid on the next falling edge, before it drives anything else. The vector table is applied back to back with in_valid held high, so each check also shows that the previous operation does not leak into the next one. The directed checks for a dropped in_valid and for reset sample at that same one-cycle point.

// File: rtl/psad_pkg.sv
package psad_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = WORD_W / 2;
    localparam int N_BYTES = WORD_W / BYTE_W;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SAD_B   = 3'd0,
        OP_SAD_BHI = 3'd1,
        OP_SAD_H   = 3'd2,
        OP_SAD_W   = 3'd3,
        OP_AVG_B   = 3'd4
    } psad_op_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } psad_out_t;

endpackage

// File: rtl/psad_diff_tree.sv
// Splits two words into lanes of LANE_W bits, takes the unsigned magnitude
// of each lane difference, and sums the magnitudes.
module psad_diff_tree #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] y,
    output logic [WORD_W-1:0] sum
);
    localparam int N_LANES = WORD_W / LANE_W;

    logic [LANE_W-1:0] mag [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] xl, yl;
        assign xl = x[g*LANE_W +: LANE_W];
        assign yl = y[g*LANE_W +: LANE_W];
        assign mag[g] = (xl >= yl) ? (xl - yl) : (yl - xl);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < N_LANES; i++) begin
            sum = sum + WORD_W'(mag[i]);
        end
    end
endmodule

// File: rtl/psad_avg_lanes.sv
// Per-lane average with a rounding bit taken from bit 0 of each lane of rnd.
module psad_avg_lanes #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] y,
    input  logic [WORD_W-1:0] rnd,
    output logic [WORD_W-1:0] avg
);
    localparam int N_LANES = WORD_W / LANE_W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [LANE_W:0] wide;
        assign wide = {1'b0, x[g*LANE_W +: LANE_W]}
                    + {1'b0, y[g*LANE_W +: LANE_W]}
                    + {{LANE_W{1'b0}}, rnd[g*LANE_W]};
        assign avg[g*LANE_W +: LANE_W] = wide[LANE_W:1];
    end
endmodule

// File: rtl/psad_unit.sv
module psad_unit
    import psad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] c,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    localparam int HI_SHIFT = HALF_W;

    logic [WORD_W-1:0] sum_b, sum_h, sum_w, avg_b;
    logic [WORD_W-1:0] nxt;
    psad_out_t         q;

    psad_diff_tree #(.WORD_W(WORD_W), .LANE_W(BYTE_W)) u_sum_b (
        .x(a), .y(b), .sum(sum_b));
    psad_diff_tree #(.WORD_W(WORD_W), .LANE_W(HALF_W)) u_sum_h (
        .x(a), .y(b), .sum(sum_h));
    psad_diff_tree #(.WORD_W(WORD_W), .LANE_W(WORD_W)) u_sum_w (
        .x(a), .y(b), .sum(sum_w));
    psad_avg_lanes #(.WORD_W(WORD_W), .LANE_W(BYTE_W)) u_avg (
        .x(a), .y(b), .rnd(c), .avg(avg_b));

    always_comb begin
        case (psad_op_e'(op))
            OP_SAD_B:   nxt = c + sum_b;
            OP_SAD_BHI: nxt = c + (sum_b << HI_SHIFT);
            OP_SAD_H:   nxt = c + sum_h;
            OP_SAD_W:   nxt = c + sum_w;
            OP_AVG_B:   nxt = avg_b;
            default:    nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid) q.data <= nxt;
        end
    end

    assign out_valid = q.vld;
    assign result    = q.data;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R1
    sad_b_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == OP_SAD_B)
            |-> ((result - $past(c)) <= WORD_W'(N_BYTES * ((1 << BYTE_W) - 1))));
    // R2
    sad_bhi_low_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == OP_SAD_BHI)
            |-> ((result[HI_SHIFT-1:0] - $past(c[HI_SHIFT-1:0])) == '0));
    // R3
    sad_h_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == OP_SAD_H)
            |-> ((result - $past(c)) <= WORD_W'(2 * ((1 << HALF_W) - 1))));
    // R9
    bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) > OP_AVG_B) |-> (result == '0));

    for (genvar g = 0; g < N_BYTES; g++) begin : g_avg_chk
        // R5
        avg_range_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && $past(op) == OP_AVG_B)
              |-> ((result[g*BYTE_W +: BYTE_W] >= $past(a[g*BYTE_W +: BYTE_W])
                    || result[g*BYTE_W +: BYTE_W] >= $past(b[g*BYTE_W +: BYTE_W]))
                && (result[g*BYTE_W +: BYTE_W] <= $past(a[g*BYTE_W +: BYTE_W])
                    || result[g*BYTE_W +: BYTE_W] <= $past(b[g*BYTE_W +: BYTE_W]))));
    end
endmodule

// File: tb/tb_psad_unit.sv
module tb_psad_unit;
    localparam int NV = 15;
    // {req, op, a, b, c, expected}
    localparam logic [134:0] VEC [NV] = '{
        {4'd1,  3'd0, 32'h01020304, 32'h04030201, 32'h00000010, 32'h00000018}, // R1
        {4'd1,  3'd0, 32'hFF00FF00, 32'h00FF00FF, 32'h00000000, 32'h000003FC}, // R1
        {4'd2,  3'd1, 32'h01020304, 32'h04030201, 32'h00000005, 32'h00080005}, // R2
        {4'd3,  3'd2, 32'h00010010, 32'h00030001, 32'h00000100, 32'h00000111}, // R3
        {4'd3,  3'd2, 32'hFFFF0000, 32'h0000FFFF, 32'h00000000, 32'h0001FFFE}, // R3
        {4'd4,  3'd3, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFE}, // R4
        {4'd4,  3'd3, 32'h80000000, 32'h7FFFFFFF, 32'h00000002, 32'h00000003}, // R4
        {4'd6,  3'd3, 32'hFFFFFFFF, 32'h00000000, 32'h00000002, 32'h00000001}, // R6
        {4'd6,  3'd1, 32'hFF000000, 32'h00000000, 32'hFF010000, 32'h00000000}, // R6
        {4'd5,  3'd4, 32'h01030507, 32'h02040608, 32'h00010001, 32'h01040508}, // R5
        {4'd5,  3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h01010101, 32'hFFFFFFFF}, // R5
        {4'd10, 3'd4, 32'h01030507, 32'h02040608, 32'hFEFFFEFF, 32'h01040508}, // R10
        {4'd9,  3'd5, 32'h12345678, 32'h00000000, 32'h00000001, 32'h00000000}, // R9
        {4'd9,  3'd7, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 32'h00000000}, // R9
        {4'd1,  3'd0, 32'h00000000, 32'h00000000, 32'hCAFEF00D, 32'hCAFEF00D}  // R1
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] a = '0, b = '0, c = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    psad_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .c(c), .out_valid(out_valid), .result(result));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, want %h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R8 result after reset", result, 32'd0);
        rst = 1'b0;

        // R7: table applied back to back with in_valid held high
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            op = VEC[i][130:128];
            a  = VEC[i][127:96];
            b  = VEC[i][95:64];
            c  = VEC[i][63:32];
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VEC[i][134:131], i), result, VEC[i][31:0]);
            check("R7 valid high", {31'd0, out_valid}, 32'd1);
        end

        // R7: dropped in_valid clears valid one cycle later
        in_valid = 1'b0;
        op = 3'd3; a = 32'h5; b = 32'h1; c = 32'h0;
        @(negedge clk);
        check("R7 valid low", {31'd0, out_valid}, 32'd0);

        // R7: valid returns with a fresh result
        in_valid = 1'b1;
        @(negedge clk);
        check("R7 valid again", {31'd0, out_valid}, 32'd1);
        check("R4 after gap", result, 32'h00000004);

        // R8: reset wins over in_valid
        rst = 1'b1;
        op = 3'd0; a = 32'hFFFFFFFF; b = 32'h0; c = 32'h1;
        @(negedge clk);
        check("R8 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R8 result in reset", result, 32'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R8 valid after release", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule